// File: doc/BRIEF.md
# Clock Frequency Ratio Meter

This block measures a fast reference clock against a slow low-power clock of about 32768 Hz. It runs entirely in the fast domain. The slow clock is brought in through a synchroniser and a rising-edge detector. A window state machine counts fast cycles over four slow-clock periods, and a result latch keeps the count of the last complete window. Software converts the count into a frequency as count × 32768 / 4. Because that conversion depends on the count, the count must be exact at both ends of the window.

Software drives the block through one 32-bit register. Bit 31 is the run bit: writing 1 starts repeated measurement and writing 0 stops the counting logic to save power. Bits 12:0 hold the latched 13-bit count. All other bits read as zero.

The window state machine has three states:
- **IDLE**: the run bit is clear.
- **ARM**: waiting for the first slow-clock edge.
- **COUNT**: a window is open.

It has these transitions:
- IDLE→ARM when the run bit is set.
- ARM→COUNT on a detected slow edge.
- COUNT→COUNT at the fourth edge. The window closes, the result is latched and the next window opens in the same cycle.
- ARM→IDLE and COUNT→IDLE whenever the run bit is cleared.

Top module: `clk_ratio_meter`

## Requirements
- R1: Bit 31 of the register is the run bit. A write sets it to the written bit 31, and a read returns it in bit 31.
- R2: With the run bit set, a window opens at the first detected slow rising edge. The latched count equals the number of fast cycles in the four slow periods that follow. With a slow period of exactly P fast cycles, bits 12:0 read 4·P.
- R3: Windows repeat back to back while the run bit stays set. The latched value changes only at the end of a complete window. A read taken before the first window after enabling completes returns the previously latched value, never a partial count.
- R4: A count above 8191 is latched as 0x1FFF (saturated, not wrapped).
- R5: Clearing the run bit aborts the window at once and latches nothing. The previously latched value is kept. A later enable starts a fresh, exact window.
- R6: Reset clears both the run bit and the latched count to zero.
- R7: Bits 30:13 read as zero. Written bits 30:0 have no effect on the latched count.
- R8: After enabling, a valid count is readable no later than five slow periods plus a few fast cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock being measured |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | Slow low-power clock, asynchronous to clk |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data: run bit in 31, count in 12:0 |

## Verification
A state machine that opens its window one edge too early or too late, or that miscounts at a window boundary, shows up in bits 12:0 as a value other than 4·P. This appears at the first window end after enabling, which is within five slow periods. A state machine that keeps counting after the run bit is cleared would overwrite the kept value within four slow periods. A counter that is not cleared when the run bit drops would give a wrong first count after re-enabling. Counts near 8191 expose wrapping instead of saturation at the first window end.

// File: rtl/crm_pkg.sv
package crm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } crm_state_e;
endpackage

// File: rtl/crm_edge_sync.sv
module crm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // Synchroniser stages plus one history flop for edge detection.
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // Two slow edges never arrive back to back in the fast domain.
    p_rise_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/crm_window_fsm.sv
module crm_window_fsm
    import crm_pkg::*;
#(
    parameter int RES_W     = 13,
    parameter int WIN_EDGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             edge_i,
    output logic             done_o,
    output logic [RES_W-1:0] cnt_o
);
    localparam int EW = $clog2(WIN_EDGES + 1);
    localparam logic [RES_W-1:0] CNT_MAX  = '1;
    localparam logic [EW-1:0]    LAST_EDG = EW'(WIN_EDGES - 1);

    crm_state_e       state_q, state_d;
    logic [RES_W-1:0] cnt_q;
    logic [EW-1:0]    edg_q;
    logic             last_edge;

    assign last_edge = edge_i && (edg_q == LAST_EDG);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_i) state_d = ST_ARM;
            ST_ARM:   if (!en_i) state_d = ST_IDLE;
                      else if (edge_i) state_d = ST_COUNT;
            ST_COUNT: if (!en_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Window counters: cleared outside an open window and at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            edg_q <= '0;
        end else if (state_q == ST_COUNT && en_i && !last_edge) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (edge_i) edg_q <= edg_q + 1'b1;
        end else begin
            cnt_q <= '0;
            edg_q <= '0;
        end
    end

    assign done_o = (state_q == ST_COUNT) && en_i && last_edge;
    assign cnt_o  = cnt_q;

    p_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q == ST_IDLE);
    p_count_via_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> $past(state_q) != ST_IDLE);
endmodule

// File: rtl/crm_result_latch.sv
module crm_result_latch #(
    parameter int RES_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [RES_W-1:0] cnt_i,
    output logic [RES_W-1:0] result_o
);
    localparam logic [RES_W-1:0] CNT_MAX = '1;

    // The closing cycle itself adds one; a counter already at the ceiling stays saturated.
    logic [RES_W-1:0] final_cnt;
    assign final_cnt = (cnt_i == CNT_MAX) ? CNT_MAX : cnt_i + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)      result_o <= '0;
        else if (load_i) result_o <= final_cnt;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(result_o));
endmodule

// File: rtl/clk_ratio_meter.sv
module clk_ratio_meter #(
    parameter int DATA_W    = 32,
    parameter int RES_W     = 13,
    parameter int WIN_EDGES = 4,
    parameter int SYNC_STG  = 2,
    parameter int EN_BIT    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic             en_q;
    logic             slow_rise;
    logic             win_done;
    logic [RES_W-1:0] win_cnt;
    logic [RES_W-1:0] result;

    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (reg_wr) en_q <= reg_wdata[EN_BIT];
    end

    crm_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(slow_clk), .rise_o(slow_rise)
    );

    crm_window_fsm #(.RES_W(RES_W), .WIN_EDGES(WIN_EDGES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_i(en_q), .edge_i(slow_rise),
        .done_o(win_done), .cnt_o(win_cnt)
    );

    crm_result_latch #(.RES_W(RES_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load_i(win_done), .cnt_i(win_cnt),
        .result_o(result)
    );

    // Read mux: unused bits are zero.
    always_comb begin
        reg_rdata              = '0;
        reg_rdata[EN_BIT]      = en_q;
        reg_rdata[RES_W-1:0]   = result;
    end

    p_en_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[EN_BIT] == $past(reg_wdata[EN_BIT]));
endmodule

// File: tb/clk_ratio_meter_tb.sv
module clk_ratio_meter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    int slow_p = 100;
    int cur_p = 100;

    always #2ns clk = ~clk;

    clk_ratio_meter u_dut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Slow clock: period of exactly slow_p fast cycles, transitions 1 ns after a fast edge.
    initial begin
        forever begin
            int p;
            p = slow_p;
            for (int i = 0; i < p; i++) begin
                @(posedge clk);
                #1ns;
                slow_clk = (i < p / 2);
            end
        end
    end

    function automatic int exp_count(int p);
        return (4 * p > 8191) ? 8191 : 4 * p;
    endfunction

    task automatic check(string req, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic reg_write(logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic settle(int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    // Stop, switch period, restart, check early read and final count.
    task automatic measure(int p);
        int prev;
        reg_write(32'h0);
        slow_p = p;
        settle(2 * (cur_p + p) + 4);
        cur_p = p;
        prev = int'(reg_rdata[12:0]);
        reg_write(32'h8000_0000);
        settle(3);
        check("R3 no partial count", int'(reg_rdata[12:0]), prev);
        check("R1 run bit set", int'(reg_rdata[31]), 1);
        settle(5 * p + 10);
        check("R8/R2 count", int'(reg_rdata[12:0]), exp_count(p));
    endtask

    initial begin
        int unsigned r;
        r = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset value", int'(reg_rdata), 0);

        // Directed and random periods
        measure(100);
        measure(37);
        for (int k = 0; k < 6; k++) begin
            measure(20 + int'($urandom % 380));
        end

        // R4 saturation boundaries
        measure(2047);
        measure(2048);
        check("R4 saturate at 8192", int'(reg_rdata[12:0]), 8191);
        measure(2500);
        check("R4 saturate above", int'(reg_rdata[12:0]), 8191);

        // R7: low bits and gap bits are not writable
        measure(150);
        reg_write(32'hFFFF_FFFF);
        check("R7 gap bits zero", int'(reg_rdata[30:13]), 0);
        check("R7 count not written", int'(reg_rdata[12:0]), 600);
        reg_write(32'h8000_0000);

        // R3: period change while running, windows keep repeating
        slow_p = 220;
        settle(5 * cur_p + 8 * 220 + 10);
        cur_p = 220;
        check("R3 back-to-back update", int'(reg_rdata[12:0]), 880);
        settle(4 * 220 + 5);
        check("R3 steady repeat", int'(reg_rdata[12:0]), 880);

        // R5: abort mid-window keeps old value, restart is fresh
        measure(100);
        reg_write(32'h0);
        slow_p = 300;
        settle(2 * (cur_p + 300) + 4);
        cur_p = 300;
        reg_write(32'h8000_0000);
        settle(2 * 300);
        reg_write(32'h0);
        settle(3000);
        check("R5 abort keeps value", int'(reg_rdata[12:0]), 400);
        check("R5 run bit cleared", int'(reg_rdata[31]), 0);
        reg_write(32'h8000_0000);
        settle(5 * 300 + 10);
        check("R5 fresh restart", int'(reg_rdata[12:0]), 1200);

        // R6: reset clears latch and run bit
        @(negedge clk);
        rst_n = 1'b0;
        settle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset clears", int'(reg_rdata), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule